// File: doc/BRIEF.md
# Slot Interrupt Router and Trigger Unit

This block gathers the four interrupt request pins of every expansion slot on a PCI segment and folds them onto a small set of internal interrupt lines. Internal lines are numbered from 32 upward. Bit k of each control mask belongs to line 32 + k. The routing is fixed and depends on the slot. One slot spreads its four pins over four separate lines. Two slots each collapse all their pins onto a single line. The add-in slots rotate their pins across a shared group of lines, so neighbouring slots overlap. All other slots are left untranslated. Their pin numbers land below line 32, outside the masks, so they never reach the output.

For each internal line, an edge-select mask bit picks the trigger mode. In edge mode, a rising routed level produces a single one-cycle request. In level mode, the polarity mask bit decides whether the line raises the request while its routed level is high (bit set) or holds it low (bit clear). The requests of all lines are ORed into one registered interrupt output toward the processor. All inputs are plain levels sampled on every clock. There is no stream interface and so no back-pressure.

Top module: `slot_irq_router`

## Requirements
- R1: While `rst_i` is high, and in the first cycle after it is released, `irq_o` is 0.
- R2: Slot 5 pin n (input bit 5*4+n) drives mask bit n (line 32+n), and no other bit.
- R3: Every pin of slot 6 drives mask bit 4 (line 36), and every pin of slot 7 drives mask bit 5 (line 37).
- R4: Slot s in 8..12, pin n drives mask bit (s-8+n)+6, that is line (s-8+n)+38.
- R5: Pins of slots 0..4 and 13..15 map to lines 0..3, which lie below the masks, and never affect `irq_o` under any mask setting.
- R6: A line whose `edge_sel_i` bit is 1 raises `irq_o` for exactly one cycle, one clock after its routed level goes from 0 to 1. A level held high gives no further pulse.
- R7: A line whose `edge_sel_i` bit is 0 and whose `pol_i` bit is 1 drives `irq_o` high one clock after its routed level is high, and for as long as it stays high.
- R8: A line whose `edge_sel_i` bit is 0 and whose `pol_i` bit is 0 never raises `irq_o`.
- R9: Pins that share a line are ORed. A second pin rising while another pin on the same line is already high gives no new edge pulse. Requests of different lines are ORed into `irq_o` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| slot_pins_i | input | NUM_SLOTS*4 | Interrupt pin levels; bit s*4+n is pin n of slot s |
| edge_sel_i | input | MASK_W | Per-line trigger mode, 1 = edge, 0 = level |
| pol_i | input | MASK_W | Per-line level polarity, 1 = raise, 0 = hold low |
| irq_o | output | 1 | Registered interrupt request toward the processor |

## Verification
Two things can happen in the same cycle. An edge-mode line can fire its one-cycle pulse while a level-mode line is holding the output high. And two pins that collapse onto one line can rise or fall together. The bench provokes both on purpose. It raises a slot 6 pin with line 36 in edge mode while slot 5 pin 0 keeps line 32 asserted in level mode. It also drives overlapping add-in pins, for example slot 8 pin 1 and slot 9 pin 0, in staggered and in simultaneous patterns. Each cycle is judged against a behavioural model. The model recomputes the line levels, the previous levels and the expected output from the requirements, and it is compared with `irq_o` on every clock.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  localparam int LINE_BASE     = 32;
  localparam int PINS_PER_SLOT = 4;

  // Absolute internal line number for a slot/pin pair.
  function automatic int line_of(input int slot, input int pin);
    int line;
    if (slot == 5)                    line = LINE_BASE + (pin % 4);
    else if (slot == 6)               line = LINE_BASE + 4;
    else if (slot == 7)               line = LINE_BASE + 5;
    else if (slot >= 8 && slot <= 12) line = (slot - 8 + pin) + LINE_BASE + 6;
    else                              line = pin;
    return line;
  endfunction

  // Mask bit index for a slot/pin pair, or -1 when outside the masks.
  function automatic int bit_of(input int slot, input int pin, input int mask_w);
    int idx;
    idx = line_of(slot, pin) - LINE_BASE;
    if (idx < 0 || idx >= mask_w) idx = -1;
    return idx;
  endfunction

endpackage

// File: rtl/sirq_route.sv
module sirq_route
  import sirq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int MASK_W    = 32,
  localparam int PIN_W    = NUM_SLOTS * PINS_PER_SLOT
) (
  input  logic [PIN_W-1:0]  pins_i,
  output logic [MASK_W-1:0] line_lvl_o,
  output logic [PIN_W-1:0]  routed_mask_o
);

  for (genvar l = 0; l < MASK_W; l++) begin : g_line
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        for (int p = 0; p < PINS_PER_SLOT; p++) begin
          if (bit_of(s, p, MASK_W) == l) hit = hit | pins_i[s*PINS_PER_SLOT + p];
        end
      end
    end
    assign line_lvl_o[l] = hit;
  end

  for (genvar i = 0; i < PIN_W; i++) begin : g_mask
    assign routed_mask_o[i] = (bit_of(i / PINS_PER_SLOT, i % PINS_PER_SLOT, MASK_W) >= 0);
  end

endmodule

// File: rtl/sirq_trigger.sv
module sirq_trigger (
  input  logic clk_i,
  input  logic rst_i,
  input  logic lvl_i,
  input  logic edge_sel_i,
  input  logic pol_i,
  output logic req_o
);

  logic prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= 1'b0;
    else       prev_q <= lvl_i;
  end

  always_comb begin
    if (edge_sel_i) req_o = lvl_i & ~prev_q;
    else            req_o = lvl_i & pol_i;
  end

  // R6: an edge request never lasts two cycles while edge mode stays selected
  p_edge_single_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (edge_sel_i && req_o) |=> !(edge_sel_i && req_o));

endmodule

// File: rtl/slot_irq_router.sv
module slot_irq_router
  import sirq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int MASK_W    = 32,
  localparam int PIN_W    = NUM_SLOTS * PINS_PER_SLOT
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [PIN_W-1:0]  slot_pins_i,
  input  logic [MASK_W-1:0] edge_sel_i,
  input  logic [MASK_W-1:0] pol_i,
  output logic              irq_o
);

  logic [MASK_W-1:0] line_lvl;
  logic [MASK_W-1:0] line_req;
  logic [PIN_W-1:0]  routed_mask;

  sirq_route #(.NUM_SLOTS(NUM_SLOTS), .MASK_W(MASK_W)) u_route (
    .pins_i        (slot_pins_i),
    .line_lvl_o    (line_lvl),
    .routed_mask_o (routed_mask)
  );

  for (genvar l = 0; l < MASK_W; l++) begin : g_trig
    sirq_trigger u_trig (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .lvl_i      (line_lvl[l]),
      .edge_sel_i (edge_sel_i[l]),
      .pol_i      (pol_i[l]),
      .req_o      (line_req[l])
    );
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) irq_o <= 1'b0;
    else       irq_o <= |line_req;
  end

  // R1: reset forces the output low on the following cycle
  p_reset_quiet_r1: assert property (@(posedge clk_i) rst_i |=> !irq_o);

  // R5: with every translated pin low, nothing can request
  p_untranslated_quiet_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    ((slot_pins_i & routed_mask) == '0) |=> !irq_o);

  if (NUM_SLOTS > 6 && MASK_W > 4) begin : g_chk6
    // R3/R7: any slot 6 pin with line 36 in raising level mode asserts irq_o
    p_slot6_level_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      ((|slot_pins_i[6*PINS_PER_SLOT +: PINS_PER_SLOT]) && !edge_sel_i[4] && pol_i[4])
      |=> irq_o);
  end

endmodule

// File: tb/tb_slot_irq_router.sv
`timescale 1ns/1ps
module tb_slot_irq_router;

  localparam int NS = 16;
  localparam int PW = NS * 4;

  logic          clk = 1'b0;
  logic          rst;
  logic [PW-1:0] pins;
  logic [31:0]   esel;
  logic [31:0]   pol;
  logic          irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] m_prev;
  logic        m_exp;
  string       pend_tag;

  always #2 clk = ~clk;

  slot_irq_router #(.NUM_SLOTS(NS), .MASK_W(32)) dut (
    .clk_i(clk), .rst_i(rst), .slot_pins_i(pins),
    .edge_sel_i(esel), .pol_i(pol), .irq_o(irq_o)
  );

  // Model: line a slot/pin lands on, from the requirements
  function automatic int m_line(int s, int p);
    case (s)
      5:  return 32 + p;
      6:  return 36;
      7:  return 37;
      8, 9, 10, 11, 12: return 38 + (s - 8) + p;
      default: return p;
    endcase
  endfunction

  function automatic logic [31:0] m_levels(logic [PW-1:0] pv);
    logic [31:0] r = '0;
    for (int s = 0; s < NS; s++)
      for (int p = 0; p < 4; p++) begin
        int ln = m_line(s, p);
        if (ln >= 32 && ln < 64 && pv[s*4+p]) r[ln-32] = 1'b1;
      end
    return r;
  endfunction

  // Compare previous step's prediction, then apply new inputs.
  task automatic step(input logic r, input logic [PW-1:0] pv,
                      input logic [31:0] ev, input logic [31:0] po, input string tag);
    logic [31:0] lv;
    @(negedge clk);
    if (pend_tag != "") begin
      checks++;
      if (irq_o !== m_exp) begin
        failures++;
        $display("FAIL %s: irq_o=%b expected=%b at %0t", pend_tag, irq_o, m_exp, $time);
      end
    end
    rst = r; pins = pv; esel = ev; pol = po;
    lv = m_levels(pv);
    if (r) begin
      m_exp = 1'b0; m_prev = '0;
    end else begin
      m_exp = |((ev & lv & ~m_prev) | (~ev & lv & po));
      m_prev = lv;
    end
    pend_tag = tag;
  endtask

  function automatic logic [PW-1:0] pin(int s, int p);
    logic [PW-1:0] v = '0;
    v[s*4+p] = 1'b1;
    return v;
  endfunction

  initial begin
    pend_tag = "";
    rst = 1'b1; pins = '0; esel = '0; pol = '0;
    m_prev = '0; m_exp = 1'b0;
    // R1: reset with everything asserted
    for (int i = 0; i < 3; i++) step(1'b1, '1, '0, '1, "R1");
    step(1'b0, '0, '0, '1, "R1");
    step(1'b0, '0, '0, '0, "R1");
    // R2: slot 5 pin n only on bit n
    for (int p = 0; p < 4; p++) begin
      step(1'b0, pin(5, p), '0, 32'h1 << p, "R2");
      step(1'b0, pin(5, p), '0, ~(32'h1 << p), "R2");
      step(1'b0, '0, '0, '0, "R2");
    end
    // R3: slots 6 and 7 collapse
    for (int p = 0; p < 4; p++) begin
      step(1'b0, pin(6, p), '0, 32'h1 << 4, "R3");
      step(1'b0, pin(6, p), '0, ~(32'h1 << 4), "R3");
      step(1'b0, pin(7, p), '0, 32'h1 << 5, "R3");
      step(1'b0, pin(7, p), '0, ~(32'h1 << 5), "R3");
    end
    step(1'b0, '0, '0, '0, "R3");
    // R4: add-in rotation
    for (int s = 8; s <= 12; s++)
      for (int p = 0; p < 4; p++) begin
        step(1'b0, pin(s, p), '0, 32'h1 << (6 + s - 8 + p), "R4");
        step(1'b0, pin(s, p), '0, ~(32'h1 << (6 + s - 8 + p)), "R4");
      end
    step(1'b0, '0, '0, '0, "R4");
    // R5: untranslated slots, all masks set both ways
    begin
      logic [PW-1:0] un = '0;
      for (int s = 0; s < NS; s++)
        if (s < 5 || s > 12) un[s*4 +: 4] = 4'hF;
      for (int i = 0; i < 3; i++) step(1'b0, un, '0, '1, "R5");
      step(1'b0, '0, '1, '0, "R5");
      for (int i = 0; i < 3; i++) step(1'b0, un, '1, '0, "R5");
      step(1'b0, '0, '0, '0, "R5");
    end
    // R6: single pulse on a held edge-mode line, then re-arm
    for (int i = 0; i < 5; i++) step(1'b0, pin(5, 2), '1, '0, "R6");
    step(1'b0, '0, '1, '0, "R6");
    step(1'b0, pin(5, 2), '1, '0, "R6");
    step(1'b0, pin(5, 2), '1, '0, "R6");
    step(1'b0, '0, '1, '0, "R6");
    // R7: level follows with polarity set
    for (int i = 0; i < 5; i++) step(1'b0, pin(5, 0), '0, 32'h1, "R7");
    step(1'b0, '0, '0, 32'h1, "R7");
    step(1'b0, '0, '0, 32'h1, "R7");
    // R8: polarity clear holds low
    for (int i = 0; i < 4; i++) step(1'b0, '1, '0, '0, "R8");
    step(1'b0, '0, '0, '0, "R8");
    // R9: shared line 7 bit (slot 8 pin 1, slot 9 pin 0) in edge mode
    step(1'b0, pin(8, 1), 32'h1 << 7, '0, "R9");
    step(1'b0, pin(8, 1) | pin(9, 0), 32'h1 << 7, '0, "R9");
    step(1'b0, pin(9, 0), 32'h1 << 7, '0, "R9");
    step(1'b0, '0, 32'h1 << 7, '0, "R9");
    step(1'b0, pin(8, 1) | pin(9, 0), 32'h1 << 7, '0, "R9");
    step(1'b0, pin(8, 1) | pin(9, 0), 32'h1 << 7, '0, "R9");
    step(1'b0, '0, 32'h1 << 7, '0, "R9");
    // R9: edge on line 36 in the same cycle as level on line 32
    step(1'b0, pin(5, 0), 32'h1 << 4, 32'h1, "R9");
    step(1'b0, pin(5, 0) | pin(6, 3), 32'h1 << 4, 32'h1, "R9");
    step(1'b0, pin(6, 3), 32'h1 << 4, 32'h1, "R9");
    step(1'b0, pin(6, 3), 32'h1 << 4, 32'h1, "R9");
    step(1'b0, '0, '0, '0, "R9");
    // Mixed random traffic
    for (int i = 0; i < 400; i++) begin
      logic [PW-1:0] rp;
      rp = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      step(1'b0, rp, (i % 50 < 25) ? $urandom : esel, (i % 40 < 20) ? $urandom : pol, "MIX");
    end
    step(1'b0, '0, '0, '0, "MIX");
    step(1'b0, '0, '0, '0, "MIX");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule